// File: doc/BRIEF.md
# Software-Managed Variable-Page Translation Buffer

This block is a fully associative address translation buffer that software loads and maintains. It has no table walker of its own. Each of its entries is a pair of 32-bit words. The tag word names an effective page, gives that page's size and says whether the entry is live. The data word gives the real page, the execute and write rights, a 4-bit zone number and four cache attribute bits. Software writes and reads either word of any entry by index. A combinational lookup port searches every entry at once and returns the index of the matching entry, the translated real address and the rights and attributes of that entry.

Each entry carries its own 3-bit size code, so both the compare mask and the split between real page and offset change from one entry to the next within a single search. The block also holds a round-robin index that suggests the next victim slot. It advances on every tag-word load and wraps at the entry count.

Top module: `vpage_tlb`

## Requirements
- R1: After synchronous reset, every entry is invalid, so all lookups miss, and the replacement index reads 0.
- R2: A read returns the selected word of the entry at the read index. A data word reads back exactly as written. A tag word reads back with bits 31:6 as written and bits 5:0 as zero.
- R3: An entry matches only when its valid bit (tag bit 6) is 1 and address bits 31 down to 10+2×code agree with the same bits of its page number (tag bits 31:10).
- R4: The size code sits in tag bits 9:7. Codes 0 to 7 select pages of 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB. The page number bits below the page boundary are ignored in the compare.
- R5: On a hit, the translated address takes its bits at and above 10+2×code from the real page number (data bits 31:10) and its lower bits from the effective address.
- R6: When several entries match, the lowest index is reported.
- R7: On a miss, hit is 0, and index, address, rights, zone and attributes all read 0.
- R8: A write takes effect at the next rising clock edge. A lookup in the same cycle as a write sees the old contents.
- R9: The replacement index rises by one on each tag-word write and wraps from 63 to 0.
- R10: On a hit, execute comes from data bit 9 and write from data bit 8. The zone is data bits 7:4. The attributes are data bits 3:0: write-through, cache-inhibit, coherent and guarded, from bit 3 down to bit 0.
- R11: Word select 0 addresses the tag word and 1 addresses the data word. Writing one word of an entry leaves the other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_half | input | 1 | Word select for the write (0 tag, 1 data) |
| wr_idx | input | 6 | Entry index for the write |
| wr_word | input | 32 | Word to store |
| rd_idx | input | 6 | Entry index for the read |
| rd_half | input | 1 | Word select for the read (0 tag, 1 data) |
| rd_word | output | 32 | Selected word |
| lk_ea | input | 32 | Effective address to search |
| lk_hit | output | 1 | A valid entry matched |
| lk_idx | output | 6 | Index of the winning entry |
| lk_ra | output | 32 | Translated real address |
| lk_ex | output | 1 | Execute permitted |
| lk_wr | output | 1 | Write permitted |
| lk_zone | output | 4 | Zone select of the winning entry |
| lk_attr | output | 4 | Write-through, inhibit, coherent, guarded |
| rr_idx | output | 6 | Round-robin replacement index |

## Verification
The bench builds the block with its default of 64 entries. With that depth, the top slot 63 and the six-bit replacement counter's wrap back to 0 can be reached with a few dozen writes. The loaded entries use the smallest, a middle and the two largest page sizes. Some of them overlap, so the bench covers lowest-index priority, offset splicing at several boundaries and page-number bits that the compare ignores.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

    localparam int WORD_W = 32;
    localparam int PN_LSB = 10;

    typedef enum logic {
        HALF_TAG  = 1'b0,
        HALF_DATA = 1'b1
    } half_e;

    typedef struct packed {
        logic [21:0] epn;
        logic [2:0]  psz;
        logic        vld;
    } tag_t;

    typedef struct packed {
        logic [21:0] rpn;
        logic        ex;
        logic        wr;
        logic [3:0]  zone;
        logic        wt;
        logic        ci;
        logic        coh;
        logic        grd;
    } dat_t;

    function automatic tag_t tag_unpack(input logic [WORD_W-1:0] w);
        return tag_t'(w[31:6]);
    endfunction

    function automatic logic [WORD_W-1:0] tag_pack(input tag_t t);
        return {t, 6'b0};
    endfunction

    // ones above the page offset: offset is 10 + 2*code bits
    function automatic logic [WORD_W-1:0] page_mask(input logic [2:0] code);
        return 32'hFFFF_FFFF << (PN_LSB + 2 * int'(code));
    endfunction

endpackage

// File: rtl/tlbv_store.sv
module tlbv_store
    import tlbv_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  half_e             wr_half,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    input  half_e             rd_half,
    output logic [31:0]       rd_word,
    output tag_t              tag_q [ENTRIES],
    output dat_t              dat_q [ENTRIES]
);

    logic [ENTRIES-1:0] vld_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[e].vld <= 1'b0;
            end else if (sel && wr_half == HALF_TAG) begin
                tag_q[e] <= tag_unpack(wr_word);
            end
        end

        always_ff @(posedge clk) begin
            if (sel && wr_half == HALF_DATA) begin
                dat_q[e] <= dat_t'(wr_word);
            end
        end

        assign vld_vec[e] = tag_q[e].vld;
    end

    always_comb begin
        if (rd_half == HALF_TAG) rd_word = tag_pack(tag_q[rd_idx]);
        else                     rd_word = dat_q[rd_idx];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (vld_vec == '0));

    // R2
    data_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_half == HALF_DATA) |=> (dat_q[$past(wr_idx)] == dat_t'($past(wr_word))));

endmodule

// File: rtl/tlbv_match.sv
module tlbv_match
    import tlbv_pkg::*;
(
    input  tag_t         tag,
    input  logic [31:0]  ea,
    output logic         hit
);

    logic [31:0] diff;

    always_comb begin
        diff = (ea ^ {tag.epn, 10'b0}) & page_mask(tag.psz);
        hit  = tag.vld && (diff == '0);
    end

endmodule

// File: rtl/tlbv_pick.sv
module tlbv_pick #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end

    // R6
    pick_valid_chk: assert final (!any || req[idx]);

endmodule

// File: rtl/tlbv_rr.sv
module tlbv_rr #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (step) idx <= (idx + 1'b1) & IDX_MASK;
    end

    // R9
    rr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && idx == IDX_MASK) |=> (idx == '0));

    // R9
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx));

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import tlbv_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_half,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_word,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_half,
    output logic [31:0]      rd_word,
    input  logic [31:0]      lk_ea,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [31:0]      lk_ra,
    output logic             lk_ex,
    output logic             lk_wr,
    output logic [3:0]       lk_zone,
    output logic [3:0]       lk_attr,
    output logic [IDX_W-1:0] rr_idx
);

    tag_t tag_q [ENTRIES];
    dat_t dat_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;
    half_e              wr_sel;
    half_e              rd_sel;

    assign wr_sel = half_e'(wr_half);
    assign rd_sel = half_e'(rd_half);

    tlbv_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_half (wr_sel),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .rd_idx  (rd_idx),
        .rd_half (rd_sel),
        .rd_word (rd_word),
        .tag_q   (tag_q),
        .dat_q   (dat_q)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        tlbv_match u_match (
            .tag (tag_q[e]),
            .ea  (lk_ea),
            .hit (hit_vec[e])
        );
    end

    tlbv_pick #(.N(ENTRIES)) u_pick (
        .req (hit_vec),
        .any (any_hit),
        .idx (win_idx)
    );

    tlbv_rr #(.ENTRIES(ENTRIES)) u_rr (
        .clk  (clk),
        .rst  (rst),
        .step (wr_en && wr_sel == HALF_TAG),
        .idx  (rr_idx)
    );

    tag_t        win_tag;
    dat_t        win_dat;
    logic [31:0] win_mask;

    always_comb begin
        win_tag  = tag_q[win_idx];
        win_dat  = dat_q[win_idx];
        win_mask = page_mask(win_tag.psz);
        lk_hit   = any_hit;
        lk_idx   = '0;
        lk_ra    = '0;
        lk_ex    = 1'b0;
        lk_wr    = 1'b0;
        lk_zone  = '0;
        lk_attr  = '0;
        if (any_hit) begin
            lk_idx  = win_idx;
            lk_ra   = ({win_dat.rpn, 10'b0} & win_mask) | (lk_ea & ~win_mask);
            lk_ex   = win_dat.ex;
            lk_wr   = win_dat.wr;
            lk_zone = win_dat.zone;
            lk_attr = {win_dat.wt, win_dat.ci, win_dat.coh, win_dat.grd};
        end
    end

    logic [ENTRIES-1:0] below_win;
    assign below_win = (ENTRIES'(1) << lk_idx) - ENTRIES'(1);

    // R6
    lowest_win_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ((hit_vec & below_win) == '0));

    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_ra == '0 && !lk_ex && !lk_wr && lk_zone == '0 && lk_attr == '0));

    // R8
    invalidate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == HALF_TAG && !wr_word[6]) |=> !hit_vec[$past(wr_idx)]);

    // R1
    reset_rr_chk: assert property (@(posedge clk)
        $past(rst) |-> (rr_idx == '0));

endmodule

// File: tb/sim_vpage_tlb.sv
module sim_vpage_tlb;

    localparam int CLK_T = 10;
    localparam int NV    = 12;

    typedef struct packed {
        logic [31:0] ea;
        logic        hit;
        logic [5:0]  idx;
        logic [31:0] ra;
    } vec_t;

    // lookup vectors against the entries loaded below (R3 R4 R5 R6 R7)
    localparam vec_t VECS [NV] = '{
        '{32'h10FF_FFFF, 1'b1, 6'd0,  32'h80FF_FFFF},
        '{32'h1000_0000, 1'b1, 6'd0,  32'h8000_0000},
        '{32'h1100_0000, 1'b0, 6'd0,  32'h0000_0000},
        '{32'h2000_0400, 1'b1, 6'd1,  32'h0040_0C00},
        '{32'h2000_07FC, 1'b1, 6'd1,  32'h0040_0FFC},
        '{32'h2000_1234, 1'b1, 6'd2,  32'h3000_5234},
        '{32'h2000_2000, 1'b1, 6'd3,  32'h7000_A000},
        '{32'h2000_0800, 1'b1, 6'd3,  32'h7000_8800},
        '{32'h403F_FFFC, 1'b1, 6'd63, 32'h557F_FFFC},
        '{32'h4040_0000, 1'b0, 6'd0,  32'h0000_0000},
        '{32'h2000_4000, 1'b0, 6'd0,  32'h0000_0000},
        '{32'h3000_0000, 1'b0, 6'd0,  32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_half = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_word = '0;
    logic [5:0]  rd_idx = '0;
    logic        rd_half = 1'b0;
    logic [31:0] rd_word;
    logic [31:0] lk_ea = '0;
    logic        lk_hit;
    logic [5:0]  lk_idx;
    logic [31:0] lk_ra;
    logic        lk_ex;
    logic        lk_wr;
    logic [3:0]  lk_zone;
    logic [3:0]  lk_attr;
    logic [5:0]  rr_idx;

    int total = 0;
    int bad   = 0;
    logic [5:0] exp_rr = '0;
    logic done = 1'b0;

    always #(CLK_T / 2) clk = ~clk;

    vpage_tlb u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_half(wr_half), .wr_idx(wr_idx), .wr_word(wr_word),
        .rd_idx(rd_idx), .rd_half(rd_half), .rd_word(rd_word),
        .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ra(lk_ra),
        .lk_ex(lk_ex), .lk_wr(lk_wr), .lk_zone(lk_zone), .lk_attr(lk_attr),
        .rr_idx(rr_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at falling edge, commit at rising edge, release just after
    task automatic put(input logic half, input logic [5:0] idx, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_half = half; wr_idx = idx; wr_word = w;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (!half) exp_rr = exp_rr + 6'd1;
    endtask

    task automatic look(input logic [31:0] ea);
        @(negedge clk);
        lk_ea = ea;
        #1;
    endtask

    task automatic get(input logic half, input logic [5:0] idx);
        @(negedge clk);
        rd_half = half; rd_idx = idx;
        #1;
    endtask

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        look(32'h0000_0000);
        chk("R1 hit after reset", {31'b0, lk_hit}, 32'h0);
        chk("R1 rr after reset", {26'b0, rr_idx}, 32'h0);
        // R7 outputs quiet on miss
        chk("R7 ra on miss", lk_ra, 32'h0);

        // load entries: tag word 0, data word 1 (R11)
        put(1'b0, 6'd0,  32'h1012_37C0); // 16MB, stray page bits below boundary (R4)
        put(1'b1, 6'd0,  32'h80AB_CE35); // ex, zone 3, attr 0101
        put(1'b0, 6'd1,  32'h2000_0440); // 1KB
        put(1'b1, 6'd1,  32'h0040_0DA8); // wr, zone A, attr 1000
        put(1'b0, 6'd2,  32'h2000_10FF); // 4KB, low bits set (R2)
        put(1'b1, 6'd2,  32'h3000_5300);
        put(1'b0, 6'd3,  32'h2000_0140); // 16KB overlapping 1 and 2 (R6)
        put(1'b1, 6'd3,  32'h7000_8000);
        put(1'b0, 6'd63, 32'h4000_0340); // 4MB in top slot
        put(1'b1, 6'd63, 32'h5540_000F);

        // vector table: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            look(VECS[i].ea);
            chk($sformatf("R3 hit vec%0d", i), {31'b0, lk_hit}, {31'b0, VECS[i].hit});
            chk($sformatf("R6 idx vec%0d", i), {26'b0, lk_idx}, {26'b0, VECS[i].idx});
            chk($sformatf("R5 ra vec%0d", i), lk_ra, VECS[i].ra);
        end

        // R10 rights and attributes
        look(32'h1000_0010);
        chk("R10 e0 fields", {24'b0, lk_ex, lk_wr, 2'b0, lk_zone}, {24'b0, 8'h83});
        chk("R10 e0 attr", {28'b0, lk_attr}, 32'h5);
        look(32'h2000_0400);
        chk("R10 e1 fields", {24'b0, lk_ex, lk_wr, 2'b0, lk_zone}, {24'b0, 8'h4A});
        chk("R10 e1 attr", {28'b0, lk_attr}, 32'h8);
        look(32'h7777_0000);
        chk("R7 rights on miss", {24'b0, lk_ex, lk_wr, lk_zone, 2'b0}, 32'h0);
        chk("R7 attr on miss", {28'b0, lk_attr}, 32'h0);

        // R2 readback
        get(1'b0, 6'd2);
        chk("R2 tag low bits zero", rd_word, 32'h2000_10C0);
        get(1'b1, 6'd1);
        chk("R2 data readback", rd_word, 32'h0040_0DA8);
        get(1'b0, 6'd63);
        chk("R2 tag readback top", rd_word, 32'h4000_0340);

        // R11 data write leaves tag alone
        put(1'b1, 6'd2, 32'h3100_6000);
        get(1'b0, 6'd2);
        chk("R11 tag kept", rd_word, 32'h2000_10C0);
        get(1'b1, 6'd2);
        chk("R11 data new", rd_word, 32'h3100_6000);
        look(32'h2000_1ABC);
        chk("R11 new ra", lk_ra, 32'h3100_6ABC);

        // R9 counter after five tag writes
        chk("R9 rr count", {26'b0, rr_idx}, {26'b0, exp_rr});

        // R8 same-cycle lookup sees old, next cycle sees new
        @(negedge clk);
        wr_en = 1'b1; wr_half = 1'b0; wr_idx = 6'd63; wr_word = 32'h4000_0300;
        lk_ea = 32'h4000_0000;
        #1;
        chk("R8 old contents same cycle", {31'b0, lk_hit}, 32'h1);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        exp_rr = exp_rr + 6'd1;
        chk("R8 invalid after edge", {31'b0, lk_hit}, 32'h0);

        // R9 wrap
        while (exp_rr != 6'd63) put(1'b0, 6'd20, 32'h0);
        chk("R9 rr at top", {26'b0, rr_idx}, 32'd63);
        put(1'b0, 6'd20, 32'h0);
        chk("R9 rr wrap", {26'b0, rr_idx}, 32'd0);
        put(1'b1, 6'd20, 32'h0);
        chk("R9 data write no step", {26'b0, rr_idx}, 32'd0);

        // R1 reset again clears entries
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        look(32'h1000_0000);
        chk("R1 hit after second reset", {31'b0, lk_hit}, 32'h0);
        chk("R1 rr after second reset", {26'b0, rr_idx}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule